// File: doc/BRIEF.md
# Process-slot address remapper

This block sits between a processor core and its memory management unit. It holds a 7-bit process number and uses it to move each process's private low address window into a slot of the 32-bit space that belongs to that process. The space is viewed as 128 slots of 32 MB each, numbered 0 to 127 by address bits [31:25]. A core address that falls in slot 0 leaves the block with the process number in bits [31:25] and its lower 25 bits kept. Any other address passes through untouched, so a process can still reach memory that belongs to other processes.

There are two identical remap lanes, one for instruction fetch addresses and one for data addresses, and each lane registers its result. The process number is loaded through a write port and can be read back. While the process number is 0, every address leaves the block unchanged, which switches the relocation off. Swapping processes then means writing a new process number, with no need to rebuild translation tables or flush any cached translations.

Top module: `slot_remapper`

## Requirements
- R1: While reset is high and on the first cycle after it falls, the process number is 0, the read-back word is 0 and both remapped address outputs are 0.
- R2: With a nonzero process number P, an address whose bits [31:25] are all zero leaves a lane with bits [31:25] equal to P and bits [24:0] equal to the input's bits [24:0].
- R3: An address with any of bits [31:25] set leaves a lane equal to the input address, whatever the process number.
- R4: With process number 0, every address leaves a lane unchanged.
- R5: A write cycle (write enable high) loads the process number from bits [31:25] of the write data; bits [24:0] of the write data have no effect, and without a write the process number holds.
- R6: The read-back word carries the process number in bits [31:25] and zero in bits [24:0].
- R7: A new process number applies to addresses sampled on the clock edge after the write edge; the address sampled on the write edge itself uses the old number.
- R8: The instruction lane and the data lane apply the same rule, each to its own input, with no effect of one lane's address on the other lane's output.
- R9: Each lane output is registered: the result for an address sampled at one clock edge appears after that edge and holds until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pid_we | input | 1 | Process number write enable |
| pid_wdata | input | 32 | Write data; bits [31:25] are the new process number |
| pid_rdata | output | 32 | Read-back word: process number in [31:25], zeros below |
| inst_va | input | 32 | Instruction address from the core |
| data_va | input | 32 | Data address from the core |
| inst_mva | output | 32 | Registered remapped instruction address |
| data_mva | output | 32 | Registered remapped data address |

## Verification
The assertions assume reset is applied from time zero and that the inputs are steady around each rising edge, so the value sampled one edge earlier is the one the lanes registered. They also assume nothing about address patterns, so any 32-bit value may appear on either lane. The stimulus drives all inputs on the falling edge, keeps reset high from the start, and walks every process number from 0 to 127 with random addresses inside and outside slot 0 plus the boundary addresses 0, 0x01FFFFFF and 0x02000000, different on the two lanes, and write data with random low bits.

// File: rtl/slot_remap_pkg.sv
package slot_remap_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned PID_W  = 7;
  localparam int unsigned SLOT_LSB = ADDR_W - PID_W;
  localparam int unsigned LANES = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PID_W-1:0]  pid_t;

  typedef enum logic [0:0] {
    LANE_INST = 1'b0,
    LANE_DATA = 1'b1
  } lane_e;
endpackage

// File: rtl/slot_pid_reg.sv
module slot_pid_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PID_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PID_W-1:0]  wr_pid,
  output logic [PID_W-1:0]  pid,
  output logic [ADDR_W-1:0] rd_word
);
  localparam int unsigned LOW_W = ADDR_W - PID_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      pid <= '0;
    end else if (we) begin
      pid <= wr_pid;
    end
  end

  assign rd_word = {pid, {LOW_W{1'b0}}};
endmodule

// File: rtl/slot_remap_lane.sv
module slot_remap_lane #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PID_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PID_W-1:0]  pid,
  input  logic [ADDR_W-1:0] va,
  output logic [ADDR_W-1:0] mva
);
  localparam int unsigned LOW_W = ADDR_W - PID_W;

  logic              in_low_slot;
  logic [ADDR_W-1:0] mapped;

  assign in_low_slot = (va[ADDR_W-1:LOW_W] == '0);
  assign mapped      = in_low_slot ? {pid, va[LOW_W-1:0]} : va;

  always_ff @(posedge clk) begin
    if (rst) begin
      mva <= '0;
    end else begin
      mva <= mapped;
    end
  end
endmodule

// File: rtl/slot_remapper.sv
module slot_remapper
  import slot_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pid_we,
  input  logic [ADDR_W-1:0] pid_wdata,
  output logic [ADDR_W-1:0] pid_rdata,
  input  logic [ADDR_W-1:0] inst_va,
  input  logic [ADDR_W-1:0] data_va,
  output logic [ADDR_W-1:0] inst_mva,
  output logic [ADDR_W-1:0] data_mva
);
  pid_t  cur_pid;
  addr_t lane_in  [LANES];
  addr_t lane_out [LANES];

  logic unused_wdata_low;
  assign unused_wdata_low = ^pid_wdata[SLOT_LSB-1:0];

  slot_pid_reg #(
    .ADDR_W (ADDR_W),
    .PID_W  (PID_W)
  ) u_pid (
    .clk     (clk),
    .rst     (rst),
    .we      (pid_we),
    .wr_pid  (pid_wdata[ADDR_W-1:SLOT_LSB]),
    .pid     (cur_pid),
    .rd_word (pid_rdata)
  );

  assign lane_in[LANE_INST] = inst_va;
  assign lane_in[LANE_DATA] = data_va;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    slot_remap_lane #(
      .ADDR_W (ADDR_W),
      .PID_W  (PID_W)
    ) u_lane (
      .clk (clk),
      .rst (rst),
      .pid (cur_pid),
      .va  (lane_in[g]),
      .mva (lane_out[g])
    );
  end

  assign inst_mva = lane_out[LANE_INST];
  assign data_mva = lane_out[LANE_DATA];
endmodule

// File: rtl/slot_remapper_chk.sv
module slot_remapper_chk
  import slot_remap_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pid_we,
  input logic [ADDR_W-1:0] pid_wdata,
  input logic [ADDR_W-1:0] pid_rdata,
  input logic [ADDR_W-1:0] inst_va,
  input logic [ADDR_W-1:0] data_va,
  input logic [ADDR_W-1:0] inst_mva,
  input logic [ADDR_W-1:0] data_mva
);
  // R6: low field of read-back is always zero
  a_r6_rd_low_zero: assert property (@(posedge clk) disable iff (rst)
    pid_rdata[SLOT_LSB-1:0] == '0);

  // R5: write loads the top field of write data
  a_r5_write_loads: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pid_we)) |->
      pid_rdata[ADDR_W-1:SLOT_LSB] == $past(pid_wdata[ADDR_W-1:SLOT_LSB]));

  // R5: no write, no change
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pid_we)) |-> $stable(pid_rdata));

  // R3: addresses outside slot 0 pass through (instruction lane)
  a_r3_inst_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inst_va[ADDR_W-1:SLOT_LSB]) != '0) |->
      inst_mva == $past(inst_va));

  // R3, R8: same on the data lane
  a_r3_data_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(data_va[ADDR_W-1:SLOT_LSB]) != '0) |->
      data_mva == $past(data_va));

  // R4: process number zero disables the remap
  a_r4_zero_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pid_rdata) == '0) |->
      (inst_mva == $past(inst_va) && data_mva == $past(data_va)));

  // R2, R7: slot-0 address picks up the number held at the sampling edge
  a_r2_inst_slot: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inst_va[ADDR_W-1:SLOT_LSB]) == '0) |->
      (inst_mva[ADDR_W-1:SLOT_LSB] == $past(pid_rdata[ADDR_W-1:SLOT_LSB]) &&
       inst_mva[SLOT_LSB-1:0] == $past(inst_va[SLOT_LSB-1:0])));

  a_r2_data_slot: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(data_va[ADDR_W-1:SLOT_LSB]) == '0) |->
      (data_mva[ADDR_W-1:SLOT_LSB] == $past(pid_rdata[ADDR_W-1:SLOT_LSB]) &&
       data_mva[SLOT_LSB-1:0] == $past(data_va[SLOT_LSB-1:0])));
endmodule

bind slot_remapper slot_remapper_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pid_we    (pid_we),
  .pid_wdata (pid_wdata),
  .pid_rdata (pid_rdata),
  .inst_va   (inst_va),
  .data_va   (data_va),
  .inst_mva  (inst_mva),
  .data_mva  (data_mva)
);

// File: tb/slot_remapper_tb.sv
module slot_remapper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pid_we = 1'b0;
  logic [31:0] pid_wdata = '0;
  logic [31:0] pid_rdata;
  logic [31:0] inst_va = '0;
  logic [31:0] data_va = '0;
  logic [31:0] inst_mva;
  logic [31:0] data_mva;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int unsigned model_pid = 0;
  bit          wrote_last = 0;

  always #5 clk = ~clk;

  slot_remapper u_dut (
    .clk       (clk),
    .rst       (rst),
    .pid_we    (pid_we),
    .pid_wdata (pid_wdata),
    .pid_rdata (pid_rdata),
    .inst_va   (inst_va),
    .data_va   (data_va),
    .inst_mva  (inst_mva),
    .data_mva  (data_mva)
  );

  function automatic logic [31:0] ref_map(input logic [31:0] va, input int unsigned pid);
    longint unsigned slot_size = 64'h0200_0000;
    if (va < 32'h0200_0000) return 32'(longint'(va) + pid * slot_size);
    return va;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string lane_req(input logic [31:0] va, input int unsigned pid, input bit prior_wr);
    string s;
    if (pid == 0) s = "R4";
    else if (va < 32'h0200_0000) s = "R2";
    else s = "R3";
    if (prior_wr) s = {s, "/R7"};
    return s;
  endfunction

  // one clock: drive at falling edge, model at rising edge, compare after it (R9)
  task automatic cycle(input bit we, input logic [31:0] wd,
                       input logic [31:0] iva, input logic [31:0] dva);
    logic [31:0] exp_i, exp_d;
    int unsigned pid_used;
    bit          prior;
    @(negedge clk);
    pid_we = we; pid_wdata = wd; inst_va = iva; data_va = dva;
    @(posedge clk);
    pid_used = model_pid;
    prior = wrote_last;
    exp_i = ref_map(iva, pid_used);
    exp_d = ref_map(dva, pid_used);
    if (we) model_pid = int'(wd >> 25);
    wrote_last = we;
    #1;
    check({"R9 inst ", lane_req(iva, pid_used, prior)}, inst_mva, exp_i);
    check({"R8 data ", lane_req(dva, pid_used, prior)}, data_mva, exp_d);
    check(we ? "R5/R6 write readback" : "R5/R6 hold readback", pid_rdata, 32'(model_pid << 25));
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] in_a, out_a;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset inst", inst_mva, '0);
    check("R1 reset data", data_mva, '0);
    check("R1 reset readback", pid_rdata, '0);
    @(negedge clk);
    inst_va = 32'h0123_4567;
    data_va = 32'h8000_0000;
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 first cycle readback", pid_rdata, '0);
    check("R1/R4 first inst", inst_mva, 32'h0123_4567);
    check("R1/R4 first data", data_mva, 32'h8000_0000);

    for (int p = 0; p < 128; p++) begin
      // write with random low garbage; same-edge address uses old number (R7)
      cycle(1'b1, (32'(p) << 25) | ($urandom & 32'h01FF_FFFF),
            $urandom & 32'h01FF_FFFF, $urandom & 32'h01FF_FFFF);
      cycle(1'b0, $urandom, 32'h0000_0000, 32'h01FF_FFFF);
      cycle(1'b0, $urandom, 32'h0200_0000, 32'h0000_0000);
      for (int k = 0; k < 4; k++) begin
        in_a  = $urandom & 32'h01FF_FFFF;
        out_a = $urandom | 32'h0200_0000;
        cycle(1'b0, $urandom, in_a, out_a);
        cycle(1'b0, $urandom, out_a, in_a);
      end
      cycle(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h01FF_FFFF);
    end
    // back to zero, then to 127
    cycle(1'b1, 32'h01FF_FFFF, 32'h0000_1000, 32'h0000_2000);
    cycle(1'b0, 32'h0, 32'h0000_1000, 32'hFE00_0000);
    cycle(1'b1, 32'hFE00_0000, 32'h01FF_FFFF, 32'h0000_0004);
    cycle(1'b0, 32'h0, 32'h01FF_FFFF, 32'h0000_0004);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule